// File: doc/BRIEF.md
# Row-Multiplexed Feedback Servo with Slope Alternation

This block closes a feedback loop for each row of a time-multiplexed readout column. Every time the row sequencer visits a row it presents that row's index together with a signed error sample. The block then updates that row's integrator and returns the new 14-bit feedback DAC code for the row one clock later. Each row keeps its own integrator, so every row holds its own lock point while the column cycles through all rows in each frame.

A 2-bit mode input selects one of three behaviours. In plain locking the integral term always takes the gain's sign. In slope-alternating locking the integral contribution is negated on odd-numbered frames, so the loop holds on the opposite slope every other frame. In ramp mode the loop is bypassed and every visited row receives a shared sawtooth code. That code advances by a programmable step once every programmable number of frames, which keeps the step rate well below the frame rate. Changing the mode starts every row from a clean state.

Top module: `row_servo`

## Requirements
- R1: A visit (`row_vld_i` high with `row_i` below ROWS, default 41) produces exactly one result on the next cycle: `fb_vld_o` high, `fb_row_o` equal to the visited row and `fb_code_o` holding that row's code. A visit with `row_i` at or above ROWS produces no result.
- R2: Each row has its own integrator. A visit changes only the integrator of the visited row.
- R3: In locking modes (`mode_i` 0 = plain, 3 = treated as plain, 1 = alternating) the integral term is `(ki_i*err_i) >>> SHIFT` and the proportional term is `(kp_i*err_i) >>> SHIFT`. Both are signed products with an arithmetic (floor) shift, SHIFT defaulting to 8. The new integrator is the old integrator plus the integral term, and the output code is the new integrator plus the proportional term.
- R4: The stored integrator and the output code both saturate to the range 0..16383. They never wrap.
- R5: In alternating mode (`mode_i` = 1) the integral term is added on even frames and subtracted on odd frames. Frames are numbered from 0 after reset or after a mode change, and each `frame_i` pulse starts the next frame. A visit in the same cycle as `frame_i` belongs to the new frame. The parity counts frames in every mode.
- R6: In ramp mode (`mode_i` = 2) the integrators are not updated and the error and gains have no effect. Every visit returns a shared ramp code. On each `frame_i` pulse a divider count advances, and when it equals `ramp_div_i` it returns to 0 and the ramp code grows by `ramp_step_i` modulo 16384. A pulse in the same cycle as a visit takes effect first.
- R7: A change of `mode_i` clears every row's integrator, the frame parity, the ramp code and the ramp divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 plain lock, 1 alternating lock, 2 ramp, 3 plain lock |
| frame_i | input | 1 | Single-cycle start-of-frame pulse |
| row_vld_i | input | 1 | Row visit strobe |
| row_i | input | ROW_W (6) | Visited row index |
| err_i | input | ERR_W (16) | Signed error sample |
| kp_i | input | GAIN_W (16) | Signed proportional gain |
| ki_i | input | GAIN_W (16) | Signed integral gain |
| ramp_step_i | input | DAC_W (14) | Ramp increment |
| ramp_div_i | input | DIV_W (8) | Ramp advances once every ramp_div_i+1 frames |
| fb_vld_o | output | 1 | Result strobe |
| fb_row_o | output | ROW_W (6) | Row of the result |
| fb_code_o | output | DAC_W (14) | Feedback DAC code |

## Verification
Every result is due exactly one cycle after its visit, because there is a single output register after the combinational update. A frame pulse or a mode change affects a visit in the same cycle and every later visit. The bench drives each input on a falling edge, holds it across one rising edge, and reads the outputs at the next falling edge. Frame pulses and mode changes are placed either alone in a cycle or, where the same-cycle ordering is the point of the test, together with a visit.

// File: rtl/servo_pkg.sv
package servo_pkg;
   typedef enum logic [1:0] {
      MODE_LOCK = 2'd0,
      MODE_ALT  = 2'd1,
      MODE_RAMP = 2'd2,
      MODE_RSVD = 2'd3
   } servo_mode_e;
endpackage

// File: rtl/servo_frame_ctl.sv
module servo_frame_ctl (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] mode_i,
   input  logic       frame_i,
   output logic       clr_o,
   output logic       odd_o
);
   import servo_pkg::*;

   logic [1:0] mode_q;
   logic       par_q;

   // mode change restarts numbering at frame 0; a pulse in the same cycle counts
   assign clr_o = (mode_i != mode_q);
   assign odd_o = clr_o ? frame_i : (par_q ^ frame_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= MODE_LOCK;
         par_q  <= 1'b0;
      end else begin
         mode_q <= mode_i;
         par_q  <= odd_o;
      end
   end
endmodule

// File: rtl/servo_ramp_gen.sv
module servo_ramp_gen #(
   parameter int DAC_W = 14,
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic             frame_i,
   input  logic [DAC_W-1:0] step_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [DAC_W-1:0] ramp_o
);
   logic [DAC_W-1:0] ramp_q, ramp_n;
   logic [DIV_W-1:0] cnt_q, cnt_n;

   always_comb begin
      ramp_n = clr_i ? '0 : ramp_q;
      cnt_n  = clr_i ? '0 : cnt_q;
      if (en_i && frame_i) begin
         if (cnt_n == div_i) begin
            cnt_n  = '0;
            ramp_n = ramp_n + step_i;
         end else begin
            cnt_n = cnt_n + 1'b1;
         end
      end
   end

   assign ramp_o = ramp_n;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ramp_q <= '0;
         cnt_q  <= '0;
      end else begin
         ramp_q <= ramp_n;
         cnt_q  <= cnt_n;
      end
   end
endmodule

// File: rtl/servo_int_bank.sv
module servo_int_bank #(
   parameter int ROWS  = 41,
   parameter int ROW_W = 6,
   parameter int DAC_W = 14
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [ROW_W-1:0] rd_row_i,
   output logic [DAC_W-1:0] rd_data_o,
   input  logic             we_i,
   input  logic [ROW_W-1:0] wr_row_i,
   input  logic [DAC_W-1:0] wr_data_i
);
   logic [ROWS*DAC_W-1:0] flat;

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      logic [DAC_W-1:0] cell_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            cell_q <= '0;
         end else if (we_i && (wr_row_i == ROW_W'(g))) begin
            cell_q <= wr_data_i;
         end else if (clr_i) begin
            cell_q <= '0;
         end
      end
      assign flat[g*DAC_W +: DAC_W] = cell_q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (rd_row_i == ROW_W'(r)) rd_data_o = flat[r*DAC_W +: DAC_W];
      end
   end
endmodule

// File: rtl/servo_update.sv
module servo_update #(
   parameter int ERR_W  = 16,
   parameter int GAIN_W = 16,
   parameter int DAC_W  = 14,
   parameter int SHIFT  = 8
) (
   input  logic signed [ERR_W-1:0]  err_i,
   input  logic signed [GAIN_W-1:0] kp_i,
   input  logic signed [GAIN_W-1:0] ki_i,
   input  logic                     neg_i,
   input  logic        [DAC_W-1:0]  int_i,
   output logic        [DAC_W-1:0]  int_o,
   output logic        [DAC_W-1:0]  code_o
);
   localparam int PROD_W = ERR_W + GAIN_W;
   localparam int SUM_W  = PROD_W + 2;
   localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'd1 << DAC_W) - 64'd1);

   logic signed [PROD_W-1:0] prod_i, prod_p;
   logic signed [SUM_W-1:0]  term_i, term_p, sum_int, sum_code;

   function automatic logic [DAC_W-1:0] sat(input logic signed [SUM_W-1:0] v);
      if (v < 0)         return '0;
      else if (v > MAXV) return MAXV[DAC_W-1:0];
      else               return v[DAC_W-1:0];
   endfunction

   always_comb begin
      prod_i   = ki_i * err_i;
      prod_p   = kp_i * err_i;
      term_i   = SUM_W'(prod_i) >>> SHIFT;
      term_p   = SUM_W'(prod_p) >>> SHIFT;
      if (neg_i) term_i = -term_i;
      sum_int  = $signed({{(SUM_W-DAC_W){1'b0}}, int_i}) + term_i;
      int_o    = sat(sum_int);
      sum_code = $signed({{(SUM_W-DAC_W){1'b0}}, int_o}) + term_p;
      code_o   = sat(sum_code);
   end
endmodule

// File: rtl/row_servo.sv
module row_servo #(
   parameter int ROWS   = 41,
   parameter int ERR_W  = 16,
   parameter int GAIN_W = 16,
   parameter int DAC_W  = 14,
   parameter int SHIFT  = 8,
   parameter int DIV_W  = 8,
   localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        mode_i,
   input  logic              frame_i,
   input  logic              row_vld_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [ERR_W-1:0]  err_i,
   input  logic [GAIN_W-1:0] kp_i,
   input  logic [GAIN_W-1:0] ki_i,
   input  logic [DAC_W-1:0]  ramp_step_i,
   input  logic [DIV_W-1:0]  ramp_div_i,
   output logic              fb_vld_o,
   output logic [ROW_W-1:0]  fb_row_o,
   output logic [DAC_W-1:0]  fb_code_o
);
   import servo_pkg::*;

   if (ROWS < 2)                   begin : g_bad_rows  $error("ROWS must be at least 2");        end
   if (SHIFT >= ERR_W + GAIN_W)    begin : g_bad_shift $error("SHIFT exceeds product width");    end
   if (DAC_W < 2 || DAC_W > 30)    begin : g_bad_dac   $error("DAC_W out of supported range");   end
   if (DIV_W < 1)                  begin : g_bad_div   $error("DIV_W must be at least 1");       end

   logic row_ok;
   if (ROWS == (1 << ROW_W)) begin : g_full_range
      assign row_ok = 1'b1;
   end else begin : g_part_range
      localparam logic [ROW_W:0] ROWS_C = ROWS[ROW_W:0];
      assign row_ok = ({1'b0, row_i} < ROWS_C);
   end

   logic             visit, is_ramp, is_alt, clr, odd;
   logic [DAC_W-1:0] int_rd, int_old, int_new, code, ramp;

   assign visit   = row_vld_i && row_ok;
   assign is_ramp = (mode_i == MODE_RAMP);
   assign is_alt  = (mode_i == MODE_ALT);

   servo_frame_ctl frame_i0 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode_i),
      .frame_i (frame_i),
      .clr_o   (clr),
      .odd_o   (odd)
   );

   servo_ramp_gen #(.DAC_W(DAC_W), .DIV_W(DIV_W)) ramp_i0 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (is_ramp),
      .clr_i   (clr),
      .frame_i (frame_i),
      .step_i  (ramp_step_i),
      .div_i   (ramp_div_i),
      .ramp_o  (ramp)
   );

   servo_int_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .DAC_W(DAC_W)) bank_i0 (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .rd_row_i  (row_i),
      .rd_data_o (int_rd),
      .we_i      (visit && !is_ramp),
      .wr_row_i  (row_i),
      .wr_data_i (int_new)
   );

   assign int_old = clr ? '0 : int_rd;

   servo_update #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .DAC_W(DAC_W), .SHIFT(SHIFT)) upd_i0 (
      .err_i  ($signed(err_i)),
      .kp_i   ($signed(kp_i)),
      .ki_i   ($signed(ki_i)),
      .neg_i  (is_alt && odd),
      .int_i  (int_old),
      .int_o  (int_new),
      .code_o (code)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fb_vld_o  <= 1'b0;
         fb_row_o  <= '0;
         fb_code_o <= '0;
      end else begin
         fb_vld_o <= visit;
         if (visit) begin
            fb_row_o  <= row_i;
            fb_code_o <= is_ramp ? ramp : code;
         end
      end
   end
endmodule

// File: rtl/row_servo_chk.sv
module row_servo_chk #(
   parameter int ROWS  = 41,
   parameter int ROW_W = 6,
   parameter int DAC_W = 14
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [1:0]       mode_i,
   input logic             frame_i,
   input logic             row_vld_i,
   input logic [ROW_W-1:0] row_i,
   input logic             fb_vld_o,
   input logic [ROW_W-1:0] fb_row_o,
   input logic [DAC_W-1:0] fb_code_o
);
   localparam logic [ROW_W:0] ROWS_C = ROWS[ROW_W:0];
   logic in_rng;
   assign in_rng = row_vld_i && ({1'b0, row_i} < ROWS_C);

   // R1
   visit_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_rng |=> fb_vld_o);

   // R1
   no_stray_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_rng |=> !fb_vld_o);

   // R1
   row_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_rng |=> (fb_row_o == $past(row_i)));

   // R6
   ramp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fb_vld_o && $past(fb_vld_o) && ($past(mode_i) == 2'd2) &&
       ($past(mode_i, 2) == 2'd2) && !$past(frame_i)) |-> $stable(fb_code_o));
endmodule

bind row_servo row_servo_chk #(.ROWS(ROWS), .ROW_W(ROW_W), .DAC_W(DAC_W)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .mode_i    (mode_i),
   .frame_i   (frame_i),
   .row_vld_i (row_vld_i),
   .row_i     (row_i),
   .fb_vld_o  (fb_vld_o),
   .fb_row_o  (fb_row_o),
   .fb_code_o (fb_code_o)
);

// File: tb/row_servo_tb_top.sv
module row_servo_tb_top;
   localparam int ROWS = 41;
   localparam int SH   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        frame = 1'b0;
   logic        rvld = 1'b0;
   logic [5:0]  row = '0;
   logic [15:0] err = '0;
   logic [15:0] kp = '0;
   logic [15:0] ki = '0;
   logic [13:0] rstep = '0;
   logic [7:0]  rdiv = '0;
   logic        fb_vld;
   logic [5:0]  fb_row;
   logic [13:0] fb_code;

   always #2 clk = ~clk;

   row_servo dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .frame_i(frame),
      .row_vld_i(rvld), .row_i(row), .err_i(err), .kp_i(kp), .ki_i(ki),
      .ramp_step_i(rstep), .ramp_div_i(rdiv),
      .fb_vld_o(fb_vld), .fb_row_o(fb_row), .fb_code_o(fb_code)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   int m_int [ROWS];
   bit m_odd = 1'b0;
   int g_kp = 0, g_ki = 0;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat(int v);
      if (v < 0) return 0;
      if (v > 16383) return 16383;
      return v;
   endfunction

   function automatic int model_lock(int r, int e, bit neg);
      int ti;
      ti = (g_ki * e) >>> SH;
      if (neg) ti = -ti;
      m_int[r] = sat(m_int[r] + ti);
      return sat(m_int[r] + ((g_kp * e) >>> SH));
   endfunction

   task automatic set_gains(int p, int i);
      @(negedge clk);
      g_kp = p; g_ki = i;
      kp = 16'(p); ki = 16'(i);
   endtask

   task automatic set_mode(int m);
      @(negedge clk);
      mode = 2'(m);
      @(negedge clk);
      foreach (m_int[k]) m_int[k] = 0;
      m_odd = 1'b0;
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame = 1'b1;
      @(negedge clk);
      frame = 1'b0;
      m_odd = ~m_odd;
   endtask

   task automatic visit(int r, int e, bit with_frame);
      @(negedge clk);
      rvld = 1'b1; row = 6'(r); err = 16'(e); frame = with_frame;
      @(negedge clk);
      rvld = 1'b0; frame = 1'b0;
      if (with_frame) m_odd = ~m_odd;
   endtask

   task automatic lock_visit(string req, int r, int e, bit with_frame);
      int exp;
      visit(r, e, with_frame);
      exp = model_lock(r, e, (mode == 2'd1) && m_odd);
      check({req, " valid"}, int'(fb_vld), 1);
      check({req, " row"}, int'(fb_row), r);
      check({req, " code"}, int'(fb_code), exp);
   endtask

   task automatic t_reset();
      check("R1 reset valid", int'(fb_vld), 0);
      check("R1 reset code", int'(fb_code), 0);
   endtask

   task automatic t_lock();
      set_mode(0);
      set_gains(0, 256);
      lock_visit("R3 grow", 3, 100, 0);
      lock_visit("R3 grow2", 3, 50, 0);
      lock_visit("R2 other row", 7, 40, 0);
      lock_visit("R2 row3 kept", 3, 0, 0);
      set_gains(0, 100);
      lock_visit("R3 floor shift", 7, -3, 0);
      set_gains(512, 0);
      lock_visit("R3 proportional", 3, 300, 0);
      set_gains(0, 0);
      lock_visit("R2 row7 kept", 7, 0, 0);
   endtask

   task automatic t_sat();
      set_gains(0, 256);
      lock_visit("R4 int high", 5, 20000, 0);
      lock_visit("R4 int low", 5, -30000, 0);
      set_gains(256, 0);
      lock_visit("R4 code low", 5, -50, 0);
      lock_visit("R4 code high", 5, 30000, 0);
   endtask

   task automatic t_range();
      visit(45, 100, 0);
      check("R1 out of range dropped", int'(fb_vld), 0);
      set_gains(0, 256);
      lock_visit("R1 last row", 40, 10, 0);
   endtask

   task automatic t_alt();
      set_mode(1);
      set_gains(0, 256);
      lock_visit("R5 even", 2, 100, 0);
      lock_visit("R5 even2", 2, 100, 0);
      pulse_frame();
      lock_visit("R5 odd subtract", 2, 100, 0);
      pulse_frame();
      lock_visit("R5 even add", 2, 100, 0);
      lock_visit("R5 same-cycle frame", 2, 100, 1);
      lock_visit("R7 other row cleared", 3, 0, 0);
   endtask

   task automatic t_clear();
      set_mode(0);
      lock_visit("R7 cleared on change", 2, 0, 0);
      pulse_frame();
      set_mode(1);
      lock_visit("R7 parity restart", 2, 100, 0);
   endtask

   task automatic t_ramp();
      @(negedge clk);
      rstep = 14'd5000; rdiv = 8'd1;
      set_mode(2);
      set_gains(256, 256);
      visit(0, 9999, 0);
      check("R6 ramp starts 0", int'(fb_code), 0);
      pulse_frame();
      visit(4, -2000, 0);
      check("R6 divider holds", int'(fb_code), 0);
      pulse_frame();
      visit(9, 1234, 0);
      check("R6 first step", int'(fb_code), 5000);
      for (int k = 0; k < 5; k++) pulse_frame();
      visit(0, 0, 0);
      check("R6 three steps", int'(fb_code), 15000);
      pulse_frame();
      visit(0, 0, 0);
      check("R6 wraps", int'(fb_code), 3616);
      @(negedge clk);
      rstep = 14'd1; rdiv = 8'd0;
      visit(1, 0, 1);
      check("R6 same-cycle step", int'(fb_code), 3617);
      set_mode(0);
      set_gains(0, 0);
      lock_visit("R6 ints untouched R7", 0, 0, 0);
   endtask

   initial begin
      foreach (m_int[k]) m_int[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_sat();
      t_range();
      t_alt();
      t_clear();
      t_ramp();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule